// File: doc/BRIEF.md
# Fixed-Ratio System Clock Chain

This block runs on the CPU core clock and derives four clock enables from it. Each enable is a one-cycle pulse, once per period of the slower clock it stands for: the system bus clock, the peripheral clock, the memory clock and the static-bus clock. Logic in the core clock domain uses each pulse to advance at the rate of that slower clock. The ratios form a cascade. The bus rate comes from the core clock. The peripheral and memory rates come from the bus rate. The static-bus rate comes from the peripheral rate.

Every ratio comes from configuration pins. The block samples them once, on the first clock edge after reset is released, and ignores them from then on. The static-bus divisor is read from a 16-bit configuration word. A parameter picks one of two layouts for that word:

- **Legacy layout:** a single bit chooses a divisor of 4 or 5.
- **Newer layout:** a 3-bit field gives the divisor minus one.

A second parameter says whether a memory-divisor select pin exists. When it does not, the memory divisor is fixed at 2. The block has no data stream, so every pin is a plain control or status pin.

Top module: `sysclk_ratio_chain`

## Requirements
- R1: For a bus code P of 0, 1 or 2 on `cfg_bus_code`, `bus_en` pulses once every P+2 core cycles and is never high on two consecutive cycles.
- R2: A bus code of 3 gives a bus period of 4 core cycles, the same as code 2.
- R3: `per_en` pulses on every second `bus_en` pulse and never at any other time, so the peripheral period is twice the bus period.
- R4: With the memory select present (HAS_MEM_SEL=1), `cfg_mem_full`=1 makes `mem_en` pulse on every `bus_en` pulse, and 0 makes it pulse on every second one. With HAS_MEM_SEL=0, it always pulses on every second `bus_en` pulse.
- R5: In the newer layout (LEGACY_SBUS=0), bits [15:13] of `cfg_sbus_word` hold a field S. `sbus_en` then pulses on every (S+1)-th `per_en` pulse.
- R6: In the legacy layout (LEGACY_SBUS=1), `sbus_en` pulses on every 5th `per_en` pulse when bit 11 of `cfg_sbus_word` is 1, and on every 4th when it is 0. The other bits of the word have no effect.
- R7: All configuration pins are captured on the first rising edge with `rst_n` high. Later changes on them have no effect on any output.
- R8: While reset is active, and until capture, all enables are low. Count the capture edge as edge 1. An output of period T (in core cycles) is then high exactly after edges T, 2T, 3T, and so on.
- R9: Each derived enable is high only in cycles where its parent enable is also high. The parent of `per_en` and `mem_en` is `bus_en`; the parent of `sbus_en` is `per_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus_code | input | 2 | Bus ratio code P (ratio P+2; a code of 3 acts as a ratio of 4) |
| cfg_mem_full | input | 1 | 1: memory clock runs at the bus rate; 0: at half the bus rate |
| cfg_sbus_word | input | 16 | Static-bus configuration word; which bits are decoded depends on LEGACY_SBUS |
| bus_en | output | 1 | System bus clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |
| mem_en | output | 1 | Memory clock enable pulse |
| sbus_en | output | 1 | Static-bus clock enable pulse |

## Verification
The bench builds two copies of the block side by side, fed by the same configuration pins.

- **First copy:** LEGACY_SBUS=0 with HAS_MEM_SEL=1. This reaches the 3-bit static-bus field and both memory ratios.
- **Second copy:** LEGACY_SBUS=1 with HAS_MEM_SEL=0. This reaches the 4-or-5 choice and the fixed memory divisor.

Because both copies see the same `cfg_mem_full`, a single run shows whether the memory select pin is honoured or ignored. Because both see the same `cfg_sbus_word`, a single run shows the two layouts decoding different bits of the same word. Every output is checked against an expected pulse on every cycle over long windows. These windows span the largest period (64 core cycles), including a run where the configuration pins change after capture.

// File: rtl/sysclk_chain_pkg.sv
package sysclk_chain_pkg;
  // Width of every ratio register and divider counter (holds ratios up to 15)
  parameter int RATIO_W = 4;
  // Width of the static-bus configuration word
  parameter int SBUS_WORD_W = 16;
  // Legacy layout: position of the 4-or-5 select bit
  parameter int SBUS_LEG_BIT = 11;
  // Newer layout: position and width of the divisor-minus-one field
  parameter int SBUS_FLD_LSB = 13;
  parameter int SBUS_FLD_W = 3;
  // Bus code width and the code that saturates to the largest ratio
  parameter int BUS_CODE_W = 2;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    ratio_t bus;
    ratio_t mem;
    ratio_t sbus;
  } ratio_set_t;
endpackage

// File: rtl/sysclk_cfg_latch.sv
module sysclk_cfg_latch
  import sysclk_chain_pkg::*;
#(
  parameter bit LEGACY_SBUS = 1'b0,
  parameter bit HAS_MEM_SEL = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BUS_CODE_W-1:0]  cfg_bus_code,
  input  logic                   cfg_mem_full,
  input  logic [SBUS_WORD_W-1:0] cfg_sbus_word,
  output ratio_set_t             ratios,
  output logic                   cap_done
);
  localparam ratio_t BUS_MAX = ratio_t'(4);
  localparam ratio_t BUS_OFS = ratio_t'(2);
  localparam logic [BUS_CODE_W-1:0] CODE_SAT = '1;

  ratio_set_t decoded;

  // Bus ratio: code plus two, top code pinned to the largest legal ratio
  always_comb begin
    if (cfg_bus_code == CODE_SAT) decoded.bus = BUS_MAX;
    else decoded.bus = ratio_t'(cfg_bus_code) + BUS_OFS;
  end

  // Memory divisor: selectable only when the select pin exists
  generate
    if (HAS_MEM_SEL) begin : g_mem_sel
      assign decoded.mem = cfg_mem_full ? ratio_t'(1) : ratio_t'(2);
    end else begin : g_mem_fixed
      assign decoded.mem = ratio_t'(2);
    end
  endgenerate

  // Static-bus divisor: layout picked by parameter
  generate
    if (LEGACY_SBUS) begin : g_sbus_leg
      assign decoded.sbus = cfg_sbus_word[SBUS_LEG_BIT] ? ratio_t'(5) : ratio_t'(4);
    end else begin : g_sbus_fld
      assign decoded.sbus =
        ratio_t'(cfg_sbus_word[SBUS_FLD_LSB +: SBUS_FLD_W]) + ratio_t'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done    <= 1'b0;
      ratios.bus  <= BUS_OFS;
      ratios.mem  <= ratio_t'(2);
      ratios.sbus <= ratio_t'(4);
    end else if (!cap_done) begin
      cap_done <= 1'b1;
      ratios   <= decoded;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_done) |-> $stable(ratios)) else $error("ratios moved after capture"); // R7

  AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_done) |-> cap_done) else $error("capture flag dropped"); // R7
endmodule

// File: rtl/clk_tick_divider.sv
module clk_tick_divider
  import sysclk_chain_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  ratio_t ratio,
  output logic   pulse
);
  ratio_t cnt;
  logic   at_end;

  assign at_end = (cnt == ratio - ratio_t'(1));
  assign pulse  = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) begin
      if (at_end) cnt <= '0;
      else cnt <= cnt + ratio_t'(1);
    end
  end

  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> tick) else $error("pulse without parent tick"); // R9

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != '0) |-> (cnt < ratio)) else $error("divider count out of range"); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)) else $error("count moved without tick"); // R9
endmodule

// File: rtl/sysclk_ratio_chain.sv
module sysclk_ratio_chain
  import sysclk_chain_pkg::*;
#(
  parameter bit LEGACY_SBUS = 1'b0,
  parameter bit HAS_MEM_SEL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_bus_code,
  input  logic        cfg_mem_full,
  input  logic [15:0] cfg_sbus_word,
  output logic        bus_en,
  output logic        per_en,
  output logic        mem_en,
  output logic        sbus_en
);
  localparam ratio_t PER_RATIO = ratio_t'(2);

  ratio_set_t ratios;
  logic       cap_done;

  sysclk_cfg_latch #(
    .LEGACY_SBUS (LEGACY_SBUS),
    .HAS_MEM_SEL (HAS_MEM_SEL)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_bus_code  (cfg_bus_code),
    .cfg_mem_full  (cfg_mem_full),
    .cfg_sbus_word (cfg_sbus_word),
    .ratios        (ratios),
    .cap_done      (cap_done)
  );

  // Bus divider counts core cycles once configuration is held
  clk_tick_divider u_bus (
    .clk (clk), .rst_n (rst_n), .tick (cap_done), .ratio (ratios.bus), .pulse (bus_en)
  );

  // Peripheral divider counts bus pulses
  clk_tick_divider u_per (
    .clk (clk), .rst_n (rst_n), .tick (bus_en), .ratio (PER_RATIO), .pulse (per_en)
  );

  // Memory divider counts bus pulses
  clk_tick_divider u_mem (
    .clk (clk), .rst_n (rst_n), .tick (bus_en), .ratio (ratios.mem), .pulse (mem_en)
  );

  // Static-bus divider counts peripheral pulses
  clk_tick_divider u_sbus (
    .clk (clk), .rst_n (rst_n), .tick (per_en), .ratio (ratios.sbus), .pulse (sbus_en)
  );

  AST_BUS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> !bus_en) else $error("bus enable back to back"); // R1

  AST_PER_UNDER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> bus_en) else $error("peripheral enable off bus phase"); // R3

  AST_PER_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en && $past(cap_done)) |=> !per_en) else $error("peripheral enable repeated"); // R3

  AST_MEM_UNDER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> bus_en) else $error("memory enable off bus phase"); // R4

  AST_SBUS_UNDER_PER: assert property (@(posedge clk) disable iff (!rst_n)
    sbus_en |-> per_en) else $error("static-bus enable off peripheral phase"); // R9

  AST_QUIET_PRECAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |-> !(bus_en || per_en || mem_en || sbus_en))
    else $error("enable before capture"); // R8
endmodule

// File: tb/sysclk_ratio_chain_tb_top.sv
`timescale 1ns/1ps
module sysclk_ratio_chain_tb_top;
  localparam int NCYC = 200;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_code = '0;
  logic        mem_full = 1'b0;
  logic [15:0] sbus_word = '0;

  logic n_bus, n_per, n_mem, n_sb;
  logic l_bus, l_per, l_mem, l_sb;

  int n_checks = 0;
  int n_fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // Newer static-bus layout with memory select
  sysclk_ratio_chain #(.LEGACY_SBUS(1'b0), .HAS_MEM_SEL(1'b1)) dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_bus_code (bus_code), .cfg_mem_full (mem_full),
    .cfg_sbus_word (sbus_word), .bus_en (n_bus), .per_en (n_per), .mem_en (n_mem),
    .sbus_en (n_sb)
  );

  // Legacy static-bus layout, memory divisor fixed
  sysclk_ratio_chain #(.LEGACY_SBUS(1'b1), .HAS_MEM_SEL(1'b0)) dut_leg_i (
    .clk (clk), .rst_n (rst_n), .cfg_bus_code (bus_code), .cfg_mem_full (mem_full),
    .cfg_sbus_word (sbus_word), .bus_en (l_bus), .per_en (l_per), .mem_en (l_mem),
    .sbus_en (l_sb)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  task automatic check_int(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
      report();
      $finish;
    end
  end

  // R8: hold reset with new configuration applied, outputs must stay low
  task automatic apply_reset(logic [1:0] p, logic mf, logic [15:0] w);
    @(negedge clk);
    rst_n = 1'b0;
    bus_code = p; mem_full = mf; sbus_word = w;
    repeat (3) @(negedge clk);
    check_int("R8", "enables during reset",
              int'({n_bus, n_per, n_mem, n_sb, l_bus, l_per, l_mem, l_sb}), 0);
    rst_n = 1'b1;  // released at a falling edge; next rising edge captures
  endtask

  // Expected pulse after edge k of an output with period t: k multiple of t
  function automatic bit exp_pulse(int k, int t);
    return (k % t) == 0;
  endfunction

  // One scenario: reset, capture, then compare all eight enables for NCYC edges.
  // When chg is set the configuration pins are scrambled after capture (R7).
  task automatic run_scenario(string name, logic [1:0] p, logic mf, logic [15:0] w,
                              bit chg);
    int r, mm, sn, sl;
    int e_bus, e_per, e_nmem, e_nsb, e_lbus, e_lper, e_lmem, e_lsb;
    string t_bus, t_mem, t_nsb, t_lsb, t_lmem;
    r  = (p == 2'd3) ? 4 : int'(p) + 2;
    mm = mf ? 1 : 2;
    sn = int'(w[15:13]) + 1;
    sl = w[11] ? 5 : 4;
    t_bus  = chg ? "R7" : ((p == 2'd3) ? "R2" : "R1");
    t_mem  = chg ? "R7" : "R4";
    t_lmem = chg ? "R7" : "R4";
    t_nsb  = chg ? "R7" : "R5";
    t_lsb  = chg ? "R7" : "R6";
    e_bus = 0; e_per = 0; e_nmem = 0; e_nsb = 0;
    e_lbus = 0; e_lper = 0; e_lmem = 0; e_lsb = 0;
    apply_reset(p, mf, w);
    for (int k = 1; k <= NCYC; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1 && chg) begin
        bus_code = ~p; mem_full = ~mf; sbus_word = ~w;
      end
      if (n_bus  !== exp_pulse(k, r))          e_bus++;
      if (n_per  !== exp_pulse(k, 2 * r))      e_per++;   // R3, R9
      if (n_mem  !== exp_pulse(k, r * mm))     e_nmem++;
      if (n_sb   !== exp_pulse(k, 2 * r * sn)) e_nsb++;
      if (l_bus  !== exp_pulse(k, r))          e_lbus++;
      if (l_per  !== exp_pulse(k, 2 * r))      e_lper++;
      if (l_mem  !== exp_pulse(k, 2 * r))      e_lmem++;
      if (l_sb   !== exp_pulse(k, 2 * r * sl)) e_lsb++;
    end
    check_int(t_bus, {name, " bus_en mismatches (new)"}, e_bus, 0);
    check_int(chg ? "R7" : "R3", {name, " per_en mismatches (new)"}, e_per, 0);
    check_int(t_mem, {name, " mem_en mismatches (select present)"}, e_nmem, 0);
    check_int(t_nsb, {name, " sbus_en mismatches (field layout)"}, e_nsb, 0);
    check_int(t_bus, {name, " bus_en mismatches (legacy)"}, e_lbus, 0);
    check_int(chg ? "R7" : "R9", {name, " per_en mismatches (legacy)"}, e_lper, 0);
    check_int(t_lmem, {name, " mem_en mismatches (fixed divisor)"}, e_lmem, 0);
    check_int(t_lsb, {name, " sbus_en mismatches (4-or-5 layout)"}, e_lsb, 0);
  endtask

  task automatic test_fast_bus();       // R1 R4 R5 R6 R8: code 0, full-rate memory
    run_scenario("fast", 2'd0, 1'b1, 16'h0000, 1'b0);
  endtask

  task automatic test_mid_bus();        // R1 R4 R5 R6: code 1, half-rate memory, S=2, bit 11 set
    run_scenario("mid", 2'd1, 1'b0, 16'h4800, 1'b0);
  endtask

  task automatic test_slow_bus();       // R1 R5: code 2, largest field S=7, other bits noise
    run_scenario("slow", 2'd2, 1'b1, 16'hE7FF & ~16'h0800, 1'b0);
  endtask

  task automatic test_code_three();     // R2 R6: code 3 acts as ratio 4
    run_scenario("code3", 2'd3, 1'b0, 16'h8800, 1'b0);
  endtask

  task automatic test_cfg_frozen();     // R7: pins flipped after capture
    run_scenario("frozen", 2'd0, 1'b1, 16'h2000, 1'b1);
  endtask

  initial begin
    test_fast_bus();
    test_mid_bus();
    test_slow_bus();
    test_code_three();
    test_cfg_frozen();
    done = 1'b1;
    report();
    $finish;
  end
endmodule